// File: doc/BRIEF.md
# Fixed-point store formatter

This block turns one decoded fixed-point store request into one memory write command. It computes the effective address from a base register and an offset. The offset is a signed 16-bit displacement, a displacement scaled to a multiple of four, or the value of an index register. It also produces the byte count, a per-byte lane enable mask, and the store data. The store data is taken from the low-order end of a 64-bit source register and placed left-aligned on the write data bus, either in normal byte order or byte-reversed.

Register bits follow big-endian numbering, where bit 0 is the most significant bit. A byte store therefore takes bits 56..63, a halfword store takes bits 48..63 and a word store takes bits 32..63. Update forms return the effective address to the base register in the same cycle as the write is accepted. An update form with a base field of zero is rejected as an invalid form.

Requests use a valid/ready handshake. The command sits in a single output register and is held there until the memory side accepts it.

Top module: `store_fmt_unit`

## Requirements
- R1: The size code sets the byte count on `mem_nbytes`: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R2: Without byte reversal, the byte written at address EA+i is source byte n-1-i, counted from the least significant end, where n is the byte count. Byte i sits at `mem_data[63-8i -: 8]`, and all bytes of `mem_data` at positions n and above are zero.
- R3: With `req_bswap` set, the byte written at EA+i is source byte i counted from the least significant end, so the least significant source byte goes to the lowest address. The lane placement and zero fill are the same as in R2.
- R4: When `req_amode` is 0, the offset is `req_imm` sign-extended to 64 bits.
- R5: When `req_amode` is 1, the offset is `req_imm[15:2]` followed by two zero bits, sign-extended to 64 bits. `req_imm[1:0]` has no effect on the address.
- R6: When `req_amode[1]` is 1, the offset is `rb_val`.
- R7: On a non-update request whose `req_ra_sel` is 0, the base is zero and `ra_val` has no effect. In every other case the base is `ra_val`.
- R8: On an update request, `wb_en` is high in exactly the cycle in which the write is accepted (`mem_valid` and `mem_ready` both high). In that cycle `wb_sel` equals the request's `req_ra_sel` and `wb_data` equals the effective address.
- R9: An update request with `req_ra_sel` equal to 0 is accepted. It raises `form_err` for one cycle, one cycle after acceptance, and produces no write and no writeback.
- R10: Bit k of `mem_be` is set exactly when EA[2:0] <= k < EA[2:0] + n. Lanes beyond 7 are dropped.
- R11: An accepted request appears on the memory outputs one cycle later. While `mem_valid` is high and `mem_ready` is low, the command stays stable and `req_ready` is low.
- R12: During and right after reset, `mem_valid`, `wb_en` and `form_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_size | input | 2 | Size code (R1) |
| req_amode | input | 2 | Offset mode: 0 displacement, 1 scaled, 2 or 3 indexed |
| req_update | input | 1 | Write effective address back to base register |
| req_bswap | input | 1 | Byte-reversed store data |
| req_ra_sel | input | 5 | Base register field |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| rs_val | input | 64 | Source register contents |
| req_imm | input | 16 | Immediate displacement field |
| mem_valid | output | 1 | Write command present |
| mem_ready | input | 1 | Memory side accepts the command |
| mem_addr | output | 64 | Effective address |
| mem_nbytes | output | 4 | Byte count |
| mem_be | output | 8 | Byte lane enables within the doubleword |
| mem_data | output | 64 | Left-aligned store data |
| wb_en | output | 1 | Base register writeback strobe |
| wb_sel | output | 5 | Writeback register field |
| wb_data | output | 64 | Writeback value (effective address) |
| form_err | output | 1 | Invalid update form pulse |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath, a 16-bit immediate and a 5-bit register field. With a 16-bit immediate feeding a 64-bit adder, negative displacements exercise sign extension across all 48 upper bits. A negative scaled displacement whose discarded low bits are both set shows that those bits have no effect. Eight byte lanes let the vectors reach the top lane, a halfword in the last two lanes, and an address with bit 63 set.

// File: rtl/store_fmt_pkg.sv
package store_fmt_pkg;

    localparam int XLEN   = 64;
    localparam int NB     = XLEN / 8;
    localparam int LANE_W = $clog2(NB);
    localparam int CNT_W  = LANE_W + 1;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } st_size_e;

    typedef enum logic [1:0] {
        AM_DISP   = 2'd0,
        AM_SCALED = 2'd1,
        AM_INDEX  = 2'd2,
        AM_INDEX2 = 2'd3
    } st_amode_e;

    typedef struct packed {
        logic [XLEN-1:0]  addr;
        logic [CNT_W-1:0] nbytes;
        logic [NB-1:0]    be;
        logic [XLEN-1:0]  data;
    } st_cmd_t;

    function automatic logic [CNT_W-1:0] size_bytes(input st_size_e sz);
        return CNT_W'(1) << sz;
    endfunction

endpackage

// File: rtl/st_ea_calc.sv
module st_ea_calc
    import store_fmt_pkg::*;
#(
    parameter int IMM_W  = 16,
    parameter int RIDX_W = 5
) (
    input  st_amode_e         amode,
    input  logic              update,
    input  logic [RIDX_W-1:0] ra_sel,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [XLEN-1:0]   ea,
    output logic              bad_form
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] scaled_ext;

    assign base       = (update || ra_sel != '0) ? ra_val : '0;
    assign disp_ext   = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign scaled_ext = {{EXT_W{imm[IMM_W-1]}}, imm[IMM_W-1:2], 2'b00};

    always_comb begin
        unique case (amode)
            AM_DISP:   offset = disp_ext;
            AM_SCALED: offset = scaled_ext;
            default:   offset = rb_val;
        endcase
    end

    assign ea       = base + offset;
    assign bad_form = update && (ra_sel == '0);
endmodule

// File: rtl/st_lane_mask.sv
module st_lane_mask
    import store_fmt_pkg::*;
(
    input  logic [LANE_W-1:0] addr_lo,
    input  logic [CNT_W-1:0]  nbytes,
    output logic [NB-1:0]     be
);
    logic [CNT_W:0] lane_end;

    assign lane_end = {1'b0, {1'b0, addr_lo}} + {1'b0, nbytes};

    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam logic [CNT_W:0] K = (CNT_W + 1)'(k);
        assign be[k] = (K >= {2'b00, addr_lo}) && (K < lane_end);
    end
endmodule

// File: rtl/st_data_fmt.sv
module st_data_fmt
    import store_fmt_pkg::*;
(
    input  logic [CNT_W-1:0] nbytes,
    input  logic             bswap,
    input  logic [XLEN-1:0]  rs,
    output logic [XLEN-1:0]  data
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [7:0] fwd;
        logic [7:0] rev;
        logic       used;

        assign used = (CNT_W)'(i) < nbytes;
        assign rev  = rs[8*i +: 8];

        always_comb begin
            fwd = '0;
            for (int j = 0; j < NB; j++) begin
                if (int'(nbytes) - 1 - i == j) begin
                    fwd = rs[8*j +: 8];
                end
            end
        end

        assign data[XLEN-1-8*i -: 8] = !used ? 8'h00 : (bswap ? rev : fwd);
    end
endmodule

// File: rtl/store_fmt_unit.sv
module store_fmt_unit
    import store_fmt_pkg::*;
#(
    parameter int IMM_W  = 16,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_amode,
    input  logic              req_update,
    input  logic              req_bswap,
    input  logic [RIDX_W-1:0] req_ra_sel,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [IMM_W-1:0]  req_imm,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [CNT_W-1:0]  mem_nbytes,
    output logic [NB-1:0]     mem_be,
    output logic [XLEN-1:0]   mem_data,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_sel,
    output logic [XLEN-1:0]   wb_data,
    output logic              form_err
);
    st_cmd_t           cmd_d, cmd_q;
    logic              valid_q, upd_q, err_q;
    logic [RIDX_W-1:0] sel_q;
    logic              bad_form;
    logic              fire;

    assign cmd_d.nbytes = size_bytes(st_size_e'(req_size));

    st_ea_calc #(.IMM_W(IMM_W), .RIDX_W(RIDX_W)) u_ea (
        .amode    (st_amode_e'(req_amode)),
        .update   (req_update),
        .ra_sel   (req_ra_sel),
        .ra_val   (ra_val),
        .rb_val   (rb_val),
        .imm      (req_imm),
        .ea       (cmd_d.addr),
        .bad_form (bad_form)
    );

    st_lane_mask u_mask (
        .addr_lo (cmd_d.addr[LANE_W-1:0]),
        .nbytes  (cmd_d.nbytes),
        .be      (cmd_d.be)
    );

    st_data_fmt u_fmt (
        .nbytes (cmd_d.nbytes),
        .bswap  (req_bswap),
        .rs     (rs_val),
        .data   (cmd_d.data)
    );

    assign req_ready = !valid_q || mem_ready;
    assign fire      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            upd_q   <= 1'b0;
            sel_q   <= '0;
            cmd_q   <= '0;
        end else begin
            err_q <= fire && bad_form;
            if (fire) begin
                valid_q <= !bad_form;
                upd_q   <= req_update;
                sel_q   <= req_ra_sel;
                cmd_q   <= cmd_d;
            end else if (mem_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign mem_valid  = valid_q;
    assign mem_addr   = cmd_q.addr;
    assign mem_nbytes = cmd_q.nbytes;
    assign mem_be     = cmd_q.be;
    assign mem_data   = cmd_q.data;
    assign wb_en      = valid_q && mem_ready && upd_q;
    assign wb_sel     = sel_q;
    assign wb_data    = cmd_q.addr;
    assign form_err   = err_q;
endmodule

// File: rtl/store_fmt_chk.sv
module store_fmt_chk
    import store_fmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_update,
    input logic [4:0]       req_ra_sel,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [XLEN-1:0]  mem_addr,
    input logic [CNT_W-1:0] mem_nbytes,
    input logic [NB-1:0]    mem_be,
    input logic [XLEN-1:0]  mem_data,
    input logic             wb_en,
    input logic             form_err
);
    p_hold_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
            && $stable(mem_data) && $stable(mem_be));

    p_stall_ready_r11: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |-> !req_ready);

    p_bad_form_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_update && req_ra_sel == '0
            |=> form_err && !mem_valid && !wb_en);

    p_accept_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !(req_update && req_ra_sel == '0)
            |=> mem_valid);

    p_wb_issue_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> mem_valid && mem_ready);

    p_size_r1: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> $countones(mem_nbytes) == 1);

    p_lanes_r10: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_be != '0 && $countones(mem_be) <= int'(mem_nbytes));
endmodule

bind store_fmt_unit store_fmt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_update (req_update),
    .req_ra_sel (req_ra_sel),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_nbytes (mem_nbytes),
    .mem_be     (mem_be),
    .mem_data   (mem_data),
    .wb_en      (wb_en),
    .form_err   (form_err)
);

// File: tb/sim_store_fmt_unit.sv
`timescale 1ns/1ps
module sim_store_fmt_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_amode = '0;
    logic        req_update = 1'b0;
    logic        req_bswap = 1'b0;
    logic [4:0]  req_ra_sel = '0;
    logic [63:0] ra_val = '0, rb_val = '0, rs_val = 64'h0102030405060708;
    logic [15:0] req_imm = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_addr, mem_data, wb_data;
    logic [3:0]  mem_nbytes;
    logic [7:0]  mem_be;
    logic        wb_en, form_err;
    logic [4:0]  wb_sel;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    store_fmt_unit u0 (.*);

    typedef struct packed {
        logic [1:0]  size;
        logic [1:0]  amode;
        logic        upd;
        logic        bsw;
        logic [4:0]  ra_sel;
        logic [63:0] ra;
        logic [63:0] rb;
        logic [15:0] imm;
        logic [63:0] e_addr;
        logic [3:0]  e_n;
        logic [7:0]  e_be;
        logic [63:0] e_data;
        logic        e_wb;
    } vec_t;

    // Source register is 64'h0102030405060708 for all rows.
    localparam vec_t VECS [7] = '{
        '{2'd0, 2'd0, 1'b0, 1'b0, 5'd3, 64'h1000, 64'h0, 16'h0005,
          64'h1005, 4'd1, 8'h20, 64'h0800_0000_0000_0000, 1'b0},
        '{2'd1, 2'd0, 1'b0, 1'b1, 5'd0, 64'hFFFF, 64'h0, 16'hFFFE,
          64'hFFFF_FFFF_FFFF_FFFE, 4'd2, 8'hC0, 64'h0807_0000_0000_0000, 1'b0},
        '{2'd2, 2'd2, 1'b0, 1'b0, 5'd4, 64'h2000, 64'h104, 16'h7777,
          64'h2104, 4'd4, 8'hF0, 64'h0506_0708_0000_0000, 1'b0},
        '{2'd3, 2'd1, 1'b0, 1'b0, 5'd7, 64'h4000, 64'h0, 16'hFFFB,
          64'h3FF8, 4'd8, 8'hFF, 64'h0102_0304_0506_0708, 1'b0},
        '{2'd3, 2'd3, 1'b0, 1'b1, 5'd2, 64'h8000_0000_0000_0000, 64'h10, 16'h0,
          64'h8000_0000_0000_0010, 4'd8, 8'hFF, 64'h0807_0605_0403_0201, 1'b0},
        '{2'd2, 2'd0, 1'b1, 1'b1, 5'd9, 64'h300, 64'h0, 16'h0010,
          64'h310, 4'd4, 8'h0F, 64'h0807_0605_0000_0000, 1'b1},
        '{2'd0, 2'd0, 1'b1, 1'b0, 5'd1, 64'h7, 64'h0, 16'h0,
          64'h7, 4'd1, 8'h80, 64'h0800_0000_0000_0000, 1'b1}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_size   = v.size;
        req_amode  = v.amode;
        req_update = v.upd;
        req_bswap  = v.bsw;
        req_ra_sel = v.ra_sel;
        ra_val     = v.ra;
        rb_val     = v.rb;
        req_imm    = v.imm;
    endtask

    task automatic check_cmd(input vec_t v);
        string atag;
        if (v.amode == 2'd0) atag = (v.ra_sel == 5'd0 && !v.upd) ? "R7" : "R4";
        else if (v.amode == 2'd1) atag = "R5";
        else atag = "R6";
        check("R11 valid", {63'd0, mem_valid}, 64'd1);
        check(atag, mem_addr, v.e_addr);
        check("R1", {60'd0, mem_nbytes}, {60'd0, v.e_n});
        check("R10", {56'd0, mem_be}, {56'd0, v.e_be});
        check(v.bsw ? "R3" : "R2", mem_data, v.e_data);
        check("R8 wb_en", {63'd0, wb_en}, {63'd0, v.e_wb});
        if (v.e_wb) begin
            check("R8 wb_sel", {59'd0, wb_sel}, {59'd0, v.ra_sel});
            check("R8 wb_data", wb_data, v.e_addr);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 mem_valid", {63'd0, mem_valid}, 64'd0);
        check("R12 wb_en", {63'd0, wb_en}, 64'd0);
        check("R12 form_err", {63'd0, form_err}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 req_ready", {63'd0, req_ready}, 64'd1);
        check("R12 mem_valid after", {63'd0, mem_valid}, 64'd0);

        // vector table
        foreach (VECS[i]) begin
            drive(VECS[i]);
            req_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            check_cmd(VECS[i]);
        end
        @(negedge clk);
        check("R11 drained", {63'd0, mem_valid}, 64'd0);

        // R9: update with base field zero
        drive('{2'd1, 2'd0, 1'b1, 1'b0, 5'd0, 64'h500, 64'h0, 16'h4,
                64'h0, 4'd0, 8'h0, 64'h0, 1'b0});
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 form_err", {63'd0, form_err}, 64'd1);
        check("R9 no write", {63'd0, mem_valid}, 64'd0);
        check("R9 no wb", {63'd0, wb_en}, 64'd0);
        @(negedge clk);
        check("R9 pulse end", {63'd0, form_err}, 64'd0);

        // R11: stall holds the command and blocks requests
        mem_ready = 1'b0;
        drive(VECS[2]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        drive(VECS[0]);
        check("R11 stall ready", {63'd0, req_ready}, 64'd0);
        repeat (2) @(negedge clk);
        check("R11 held addr", mem_addr, VECS[2].e_addr);
        check("R11 held data", mem_data, VECS[2].e_data);
        check("R11 still valid", {63'd0, mem_valid}, 64'd1);
        mem_ready = 1'b1;
        #0.5;
        check("R11 ready back", {63'd0, req_ready}, 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_cmd(VECS[0]);
        @(negedge clk);

        // R8: stalled update issues writeback only when accepted
        mem_ready = 1'b0;
        drive(VECS[5]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 no wb while stalled", {63'd0, wb_en}, 64'd0);
        mem_ready = 1'b1;
        #0.5;
        check("R8 wb on accept", {63'd0, wb_en}, 64'd1);
        check("R8 wb addr", wb_data, VECS[5].e_addr);
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule